// File: doc/BRIEF.md
# 64-bit Global Timer with Compare Event

A memory-mapped system timer. A 64-bit up-counter advances by one on every clock while the run bit is set. A 64-bit compare value is checked against it every cycle. When the compare unit is armed and the counter has reached or passed the compare value, a sticky event flag is set. The interrupt output is that flag gated by an interrupt-enable bit.

An optional 32-bit step register supports periodic events. With stepping enabled, every match adds the step to the compare value in the same cycle, so the next event falls one period later. Software reaches all state through a plain 32-bit register port. The 64-bit quantities are split into low and high words. The register port is control traffic rather than a data stream, so it has no valid/ready handshake: a write takes effect at the next rising edge, and read data is a combinational function of the address.

Software initialises the counter by stopping the timer and writing both halves. It reprograms the compare value by disarming the compare unit, writing the low word, then the high word, and re-arming. It reads the counter as high word, low word, then high word again, and retries if the two high reads differ.

Top module: `gtmr_top`

## Requirements
- R1: After a synchronous reset, every register (counter, control, status, compare value, step) reads zero and `irq_o` is low.
- R2: While control bit 0 (run) is set, the counter increases by exactly one per clock. While it is clear, the counter holds its value.
- R3: Writes to offset 0x00 (counter low word) and 0x04 (counter high word) load that half only while run is clear. While run is set they are ignored.
- R4: A carry out of the low counter word appears in the high word on the same edge, so a high-low-high read sequence returns a consistent value.
- R5: The control word at 0x08 holds bit 0 run, bit 1 compare arm, bit 2 interrupt enable and bit 3 auto-step. The compare low/high words (0x10/0x14) and the step register (0x18) read back what was written. Unmapped offsets read zero.
- R6: With the compare unit armed, status bit 0 at 0x0C becomes 1 one clock after the first cycle in which counter ≥ compare value (unsigned, 64 bits).
- R7: While compare arm is clear, the event flag is never set.
- R8: The event flag stays set until a write to 0x0C with bit 0 = 1. Writing 0 to bit 0 has no effect.
- R9: If a clear write and a compare match fall in the same cycle, the flag remains set.
- R10: `irq_o` is high exactly when the event flag and control bit 2 are both 1.
- R11: With auto-step set, each match adds the step register to the compare value on the same edge that sets the flag. This yields one event per period.
- R12: A bus write to either compare word in a cycle with an auto-step match takes priority: the written value is stored and that cycle's step is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| reg_sel_i | input | 1 | Register access strobe |
| reg_wr_i | input | 1 | Write qualifier for the strobe |
| reg_addr_i | input | ADDR_W | Byte offset of the register |
| reg_wdata_i | input | BUS_W | Write data |
| reg_rdata_o | output | BUS_W | Read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Event interrupt |

## Verification
Two pairs of functions can fall in the same clock. The first pair is a software clear of the flag and a new compare match. The bench provokes it by holding the counter past an armed compare value and then writing the clear, and it expects the flag to read 1 afterwards. The second pair is an auto-step advance and a bus write to the compare word. The bench keeps the counter permanently ahead of a compare value that steps by one each cycle, writes a new low word, and expects that exact value back with no step applied. A behavioural reference model runs alongside and checks the read data and the interrupt on every clock.

// File: rtl/gtmr_pkg.sv
package gtmr_pkg;

  localparam logic [4:0] OFS_CNT_LO = 5'h00;
  localparam logic [4:0] OFS_CNT_HI = 5'h04;
  localparam logic [4:0] OFS_CTRL   = 5'h08;
  localparam logic [4:0] OFS_STAT   = 5'h0C;
  localparam logic [4:0] OFS_CMP_LO = 5'h10;
  localparam logic [4:0] OFS_CMP_HI = 5'h14;
  localparam logic [4:0] OFS_STEP   = 5'h18;

  // packed from msb to lsb: bit3 auto-step, bit2 irq enable, bit1 arm, bit0 run
  typedef struct packed {
    logic step;
    logic irq;
    logic arm;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/gtmr_counter.sv
module gtmr_counter #(
  parameter int unsigned HALF_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  run_i,
  input  logic                  wr_lo_i,
  input  logic                  wr_hi_i,
  input  logic [HALF_W-1:0]     wdata_i,
  output logic [2*HALF_W-1:0]   cnt_o
);
  localparam int unsigned CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
    end else if (run_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end else begin
      if (wr_lo_i) cnt_q[HALF_W-1:0]     <= wdata_i;
      if (wr_hi_i) cnt_q[CNT_W-1:HALF_W] <= wdata_i;
    end
  end

  assign cnt_o = cnt_q;

  assert_step_one_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    run_i |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

  assert_hold_stopped_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));

  assert_write_blocked_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && (wr_lo_i || wr_hi_i)) |=> (cnt_q != $past(cnt_q)));

endmodule

// File: rtl/gtmr_compare.sv
module gtmr_compare #(
  parameter int unsigned HALF_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic [2*HALF_W-1:0]   cnt_i,
  input  logic                  arm_i,
  input  logic                  step_en_i,
  input  logic                  wr_cmp_lo_i,
  input  logic                  wr_cmp_hi_i,
  input  logic                  wr_step_i,
  input  logic                  clr_i,
  input  logic [HALF_W-1:0]     wdata_i,
  output logic [2*HALF_W-1:0]   cmp_o,
  output logic [HALF_W-1:0]     step_o,
  output logic                  flag_o
);
  localparam int unsigned CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0]  cmp_q;
  logic [HALF_W-1:0] step_q;
  logic              flag_q;
  logic              hit;
  logic              cmp_wr;

  assign hit    = arm_i && (cnt_i >= cmp_q);
  assign cmp_wr = wr_cmp_lo_i || wr_cmp_hi_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cmp_q <= '0;
    end else if (cmp_wr) begin
      if (wr_cmp_lo_i) cmp_q[HALF_W-1:0]     <= wdata_i;
      if (wr_cmp_hi_i) cmp_q[CNT_W-1:HALF_W] <= wdata_i;
    end else if (hit && step_en_i) begin
      cmp_q <= cmp_q + CNT_W'(step_q);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)          step_q <= '0;
    else if (wr_step_i) step_q <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)      flag_q <= 1'b0;
    else if (hit)   flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign cmp_o  = cmp_q;
  assign step_o = step_q;
  assign flag_o = flag_q;

  assert_no_flag_disarmed_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (!flag_q && !arm_i) |=> !flag_q);

  assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (flag_q && !clr_i) |=> flag_q);

  assert_set_beats_clear_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (arm_i && (cnt_i >= cmp_q) && clr_i) |=> flag_q);

  assert_step_advance_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    (arm_i && (cnt_i >= cmp_q) && step_en_i && !cmp_wr)
      |=> (cmp_q == $past(cmp_q) + CNT_W'($past(step_q))));

  assert_write_wins_R12: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_cmp_lo_i |=> (cmp_q[HALF_W-1:0] == $past(wdata_i)));

endmodule

// File: rtl/gtmr_top.sv
module gtmr_top
  import gtmr_pkg::*;
#(
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              reg_sel_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BUS_W-1:0]  reg_wdata_i,
  output logic [BUS_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = 2 * BUS_W;

  ctrl_t             ctrl_q;
  logic              wr;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cmp;
  logic [BUS_W-1:0]  step;
  logic              flag;

  assign wr = reg_sel_i && reg_wr_i;

  function automatic logic hit_at(input logic [ADDR_W-1:0] a, input logic [4:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_ff @(posedge clk_i) begin
    if (rst_i)                                ctrl_q <= '0;
    else if (wr && hit_at(reg_addr_i, OFS_CTRL)) ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
  end

  gtmr_counter #(.HALF_W(BUS_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .run_i   (ctrl_q.run),
    .wr_lo_i (wr && hit_at(reg_addr_i, OFS_CNT_LO)),
    .wr_hi_i (wr && hit_at(reg_addr_i, OFS_CNT_HI)),
    .wdata_i (reg_wdata_i),
    .cnt_o   (cnt)
  );

  gtmr_compare #(.HALF_W(BUS_W)) u_cmp (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .cnt_i       (cnt),
    .arm_i       (ctrl_q.arm),
    .step_en_i   (ctrl_q.step),
    .wr_cmp_lo_i (wr && hit_at(reg_addr_i, OFS_CMP_LO)),
    .wr_cmp_hi_i (wr && hit_at(reg_addr_i, OFS_CMP_HI)),
    .wr_step_i   (wr && hit_at(reg_addr_i, OFS_STEP)),
    .clr_i       (wr && hit_at(reg_addr_i, OFS_STAT) && reg_wdata_i[0]),
    .wdata_i     (reg_wdata_i),
    .cmp_o       (cmp),
    .step_o      (step),
    .flag_o      (flag)
  );

  always_comb begin
    reg_rdata_o = '0;
    if      (hit_at(reg_addr_i, OFS_CNT_LO)) reg_rdata_o = cnt[BUS_W-1:0];
    else if (hit_at(reg_addr_i, OFS_CNT_HI)) reg_rdata_o = cnt[CNT_W-1:BUS_W];
    else if (hit_at(reg_addr_i, OFS_CTRL))   reg_rdata_o = BUS_W'(ctrl_q);
    else if (hit_at(reg_addr_i, OFS_STAT))   reg_rdata_o = BUS_W'(flag);
    else if (hit_at(reg_addr_i, OFS_CMP_LO)) reg_rdata_o = cmp[BUS_W-1:0];
    else if (hit_at(reg_addr_i, OFS_CMP_HI)) reg_rdata_o = cmp[CNT_W-1:BUS_W];
    else if (hit_at(reg_addr_i, OFS_STEP))   reg_rdata_o = step;
  end

  assign irq_o = flag && ctrl_q.irq;

  assert_irq_needs_enable_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ctrl_q.irq && !(wr && hit_at(reg_addr_i, OFS_CTRL))) |=> !irq_o);

endmodule

// File: tb/gtmr_top_tb_top.sv
module gtmr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        sel, wrq;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  gtmr_top dut_i (
    .clk_i(clk), .rst_i(rst), .reg_sel_i(sel), .reg_wr_i(wrq),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  logic [63:0] m_cnt, m_cmp;
  logic [31:0] m_step;
  logic [3:0]  m_ctrl;
  logic        m_flag;

  always @(posedge clk) begin
    logic match, w;
    logic [63:0] n_cnt, n_cmp;
    logic n_flag;
    if (rst) begin
      m_cnt = 0; m_cmp = 0; m_step = 0; m_ctrl = 0; m_flag = 0;
    end else begin
      w = sel && wrq;
      match = m_ctrl[1] && (m_cnt >= m_cmp);
      n_cnt = m_cnt;
      if (m_ctrl[0]) n_cnt = m_cnt + 64'd1;
      else begin
        if (w && addr == 5'h00) n_cnt[31:0]  = wdata;
        if (w && addr == 5'h04) n_cnt[63:32] = wdata;
      end
      n_cmp = m_cmp;
      if (w && (addr == 5'h10 || addr == 5'h14)) begin
        if (addr == 5'h10) n_cmp[31:0] = wdata;
        else n_cmp[63:32] = wdata;
      end else if (match && m_ctrl[3]) n_cmp = m_cmp + {32'd0, m_step};
      n_flag = m_flag;
      if (w && addr == 5'h0C && wdata[0]) n_flag = 1'b0;
      if (match) n_flag = 1'b1;
      if (w && addr == 5'h08) m_ctrl = wdata[3:0];
      if (w && addr == 5'h18) m_step = wdata;
      m_cnt = n_cnt; m_cmp = n_cmp; m_flag = n_flag;
    end
  end

  function automatic logic [31:0] model_read(input logic [4:0] a);
    case (a)
      5'h00: return m_cnt[31:0];
      5'h04: return m_cnt[63:32];
      5'h08: return {28'd0, m_ctrl};
      5'h0C: return {31'd0, m_flag};
      5'h10: return m_cmp[31:0];
      5'h14: return m_cmp[63:32];
      5'h18: return m_step;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  initial begin
    forever begin
      @(negedge clk); #1;
      if (!rst) begin
        check("MODEL rdata", {32'd0, rdata}, {32'd0, model_read(addr)});
        check("MODEL irq", {63'd0, irq}, {63'd0, m_flag & m_ctrl[2]});
      end
    end
  end

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wrq = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; wrq = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, h1, lo, h2;
    rst = 1'b1; sel = 0; wrq = 0; addr = 0; wdata = 0;
    idle(3);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a <= 24; a += 4) begin
      rd_reg(5'(a), v);
      check("R1 reset value", {32'd0, v}, 64'd0);
    end
    check("R1 irq low", {63'd0, irq}, 64'd0);

    // R3 load while stopped, R2 hold while stopped
    wr_reg(5'h00, 32'd5);
    idle(3);
    rd_reg(5'h00, v);
    check("R3 load when stopped", {32'd0, v}, 64'd5);
    check("R2 hold when stopped", {32'd0, v}, 64'd5);

    // R2 counting, R7 no flag with cmp disarmed (cmp=0)
    wr_reg(5'h08, 32'h1);
    idle(10);
    rd_reg(5'h00, v);
    check("R2 counting", {32'd0, v}, {32'd0, m_cnt[31:0]});
    check("R2 advanced", {63'd0, v > 32'd10}, 64'd1);
    rd_reg(5'h0C, v);
    check("R7 disarmed no flag", {32'd0, v}, 64'd0);
    // R3 write ignored while running
    wr_reg(5'h00, 32'h55);
    rd_reg(5'h00, v);
    check("R3 ignored while running", {32'd0, v}, {32'd0, m_cnt[31:0]});
    check("R3 not loaded", {63'd0, v == 32'h55}, 64'd0);

    // R4 carry into high word
    wr_reg(5'h08, 32'h0);
    wr_reg(5'h00, 32'hFFFF_FFFC);
    wr_reg(5'h04, 32'd7);
    wr_reg(5'h08, 32'h1);
    idle(10);
    rd_reg(5'h04, h1);
    rd_reg(5'h00, lo);
    rd_reg(5'h04, h2);
    check("R4 high after carry", {32'd0, h1}, 64'd8);
    check("R4 consistent high reads", {32'd0, h2}, {32'd0, h1});

    // R6 compare fires on >=
    wr_reg(5'h08, 32'h0);
    wr_reg(5'h00, 32'd0);
    wr_reg(5'h04, 32'd0);
    wr_reg(5'h10, 32'd30);
    wr_reg(5'h14, 32'd0);
    wr_reg(5'h0C, 32'h1);
    wr_reg(5'h08, 32'h3);
    idle(5);
    rd_reg(5'h0C, v);
    check("R6 no flag before compare", {32'd0, v}, 64'd0);
    idle(40);
    rd_reg(5'h0C, v);
    check("R6 flag after compare", {32'd0, v}, 64'd1);

    // R10 irq gating
    check("R10 irq masked", {63'd0, irq}, 64'd0);
    wr_reg(5'h08, 32'h7);
    rd_reg(5'h08, v);
    check("R5 ctrl readback", {32'd0, v}, 64'h7);
    check("R10 irq asserted", {63'd0, irq}, 64'd1);

    // R8 sticky, write-one-to-clear
    wr_reg(5'h08, 32'h1);
    wr_reg(5'h0C, 32'h0);
    rd_reg(5'h0C, v);
    check("R8 write zero no effect", {32'd0, v}, 64'd1);
    wr_reg(5'h0C, 32'h1);
    rd_reg(5'h0C, v);
    check("R8 write one clears", {32'd0, v}, 64'd0);
    idle(3);
    rd_reg(5'h0C, v);
    check("R7 stays clear while disarmed", {32'd0, v}, 64'd0);

    // R9 clear collides with match
    wr_reg(5'h08, 32'h3);
    idle(2);
    wr_reg(5'h0C, 32'h1);
    rd_reg(5'h0C, v);
    check("R9 set wins over clear", {32'd0, v}, 64'd1);

    // R11 auto-step periodic
    wr_reg(5'h08, 32'h0);
    wr_reg(5'h00, 32'd0);
    wr_reg(5'h04, 32'd0);
    wr_reg(5'h10, 32'd10);
    wr_reg(5'h18, 32'd10);
    wr_reg(5'h0C, 32'h1);
    rd_reg(5'h18, v);
    check("R5 step readback", {32'd0, v}, 64'd10);
    wr_reg(5'h08, 32'hB);
    for (int k = 1; k <= 4; k++) begin
      v = 0;
      for (int p = 0; p < 50 && v == 0; p++) rd_reg(5'h0C, v);
      check("R11 period event seen", {32'd0, v}, 64'd1);
      wr_reg(5'h0C, 32'h1);
      rd_reg(5'h10, v);
      check("R11 compare advanced", {32'd0, v}, 64'(10 * (k + 1)));
      rd_reg(5'h0C, v);
      check("R11 single event per match", {32'd0, v}, 64'd0);
    end

    // R12 bus write beats auto-step
    wr_reg(5'h08, 32'h0);
    wr_reg(5'h00, 32'd100);
    wr_reg(5'h10, 32'd50);
    wr_reg(5'h18, 32'd1);
    wr_reg(5'h08, 32'hB);
    idle(3);
    wr_reg(5'h10, 32'hABCD_0000);
    rd_reg(5'h10, v);
    check("R12 written compare kept", {32'd0, v}, 64'hABCD_0000);
    rd_reg(5'h1C, v);
    check("R5 unmapped reads zero", {32'd0, v}, 64'd0);

    idle(2);
    finish_run();
  end
endmodule